// File: doc/BRIEF.md
# Idle Handshake Acknowledge Controller

This block sits inside a serial peripheral and answers the idle request raised by a power manager that wants to stop the peripheral's clocks. A 2-bit idle policy field selects how the answer is made. The peripheral can acknowledge at once, refuse for good, or acknowledge only when its internal activity has drained. A second 2-bit field picks which clock domains are checked in the activity-based policy. The same field also picks which clocks the power manager may stop once the acknowledge is given.

Activity arrives grouped by clock domain. The interface-clock side reports pending bus transactions, pending interrupt lines, pending DMA requests and internal register accesses. The functional-clock side reports a busy shift engine and an external chip select. Chip select counts as activity only when the peripheral is a slave. The acknowledge is registered and held until the request goes away. Two gate-enable hints tell the clock manager which clocks it may stop while the acknowledge stands.

Top module: `idle_ack_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, idle_ack_o, iclk_gate_en_o and fclk_gate_en_o are 0.
- R2: With idle_mode_i = 2'b00 (forced), a high idle_req_i sets idle_ack_o one clock later whatever activity is present. Both gate hints are then 1.
- R3: With idle_mode_i = 2'b01 (refuse), idle_ack_o is never set and both hints stay 0.
- R4: The unused code idle_mode_i = 2'b11 behaves exactly like 2'b01: no acknowledge and no hints.
- R5: With idle_mode_i = 2'b10 (activity-based) and clk_keep_i = 2'b00, the acknowledge is given only in a cycle where both the interface domain and the functional domain are idle. Both hints are then 1.
- R6: clk_keep_i bit 0 = 1 keeps the interface clock on. Interface-domain activity is then ignored, and iclk_gate_en_o stays 0 during the acknowledge. With clk_keep_i = 2'b01 only functional activity is checked, and fclk_gate_en_o is 1.
- R7: clk_keep_i bit 1 = 1 keeps the functional clock on. Functional-domain activity is then ignored, and fclk_gate_en_o stays 0 during the acknowledge. With clk_keep_i = 2'b10 only interface activity is checked, and iclk_gate_en_o is 1.
- R8: With activity-based policy and clk_keep_i = 2'b11, the acknowledge follows the request without regard to any activity, and both hints stay 0.
- R9: cs_active_i counts as functional-domain activity only when master_mode_i = 0 (slave). When master_mode_i = 1 it is ignored.
- R10: Once set, idle_ack_o stays 1 while idle_req_i is 1. It clears on the first clock edge that sees idle_req_i low, and it is not set again without idle_req_i being high at a clock edge.
- R11: A gate hint is 1 only while idle_ack_o is 1. Its value is captured from the policy and clk_keep_i in the cycle the acknowledge is granted.
- R12: reg_access_i counts as interface-domain activity in both master and slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req_i | input | 1 | Idle request from the power manager |
| idle_mode_i | input | 2 | Acknowledge policy: 00 forced, 01 refuse, 10 activity-based, 11 unused (refuse) |
| clk_keep_i | input | 2 | Bit 0 keeps the interface clock on, bit 1 keeps the functional clock on |
| master_mode_i | input | 1 | 1 = master, 0 = slave |
| bus_pend_i | input | 1 | Bus transaction pending |
| irq_pend_i | input | N_IRQ | Pending interrupt lines |
| dma_pend_i | input | N_DMA | Pending DMA requests |
| reg_access_i | input | 1 | Internal register access in progress |
| shift_busy_i | input | 1 | Shift engine busy |
| cs_active_i | input | 1 | External chip select asserted |
| idle_ack_o | output | 1 | Idle acknowledge |
| iclk_gate_en_o | output | 1 | Interface clock may be stopped |
| fclk_gate_en_o | output | 1 | Functional clock may be stopped |

## Verification
The forced policy is driven with every activity source high. This shows that it ignores activity. The activity-based policy is driven with a single source active at a time, under each clk_keep_i code. These runs show which domain each code masks, and which hint it raises. Chip select and register access are each toggled in both master and slave mode, which shows that only chip select depends on the role. Request drop, request hold and policy changes during an acknowledge show that the acknowledge and the captured hints are held, then released on time.

// File: rtl/idle_ack_pkg.sv
package idle_ack_pkg;

    typedef enum logic [1:0] {
        POL_FORCE  = 2'b00,
        POL_REFUSE = 2'b01,
        POL_ACTIVE = 2'b10,
        POL_UNUSED = 2'b11
    } idle_pol_e;

    typedef struct packed {
        logic ack;
        logic gate_i;
        logic gate_f;
    } hs_state_t;

endpackage

// File: rtl/idle_pol_dec.sv
module idle_pol_dec
    import idle_ack_pkg::*;
(
    input  logic [1:0] idle_mode_i,
    input  logic [1:0] clk_keep_i,
    output logic       pol_force_o,
    output logic       pol_active_o,
    output logic       chk_i_o,
    output logic       chk_f_o,
    output logic       stop_i_ok_o,
    output logic       stop_f_ok_o
);
    idle_pol_e pol;

    always_comb begin
        pol          = idle_pol_e'(idle_mode_i);
        pol_force_o  = (pol == POL_FORCE);
        pol_active_o = (pol == POL_ACTIVE);
        // a domain whose clock is kept running is neither checked nor stopped
        chk_i_o      = ~clk_keep_i[0];
        chk_f_o      = ~clk_keep_i[1];
        stop_i_ok_o  = ~clk_keep_i[0];
        stop_f_ok_o  = ~clk_keep_i[1];
    end

endmodule

// File: rtl/idle_act_qual.sv
module idle_act_qual #(
    parameter int N_IRQ = 4,
    parameter int N_DMA = 2
) (
    input  logic             master_mode_i,
    input  logic             bus_pend_i,
    input  logic [N_IRQ-1:0] irq_pend_i,
    input  logic [N_DMA-1:0] dma_pend_i,
    input  logic             reg_access_i,
    input  logic             shift_busy_i,
    input  logic             cs_active_i,
    output logic             busy_i_o,
    output logic             busy_f_o
);
    always_comb begin
        busy_i_o = bus_pend_i | (|irq_pend_i) | (|dma_pend_i) | reg_access_i;
        // external select only matters when another device drives the bus
        busy_f_o = shift_busy_i | (~master_mode_i & cs_active_i);
    end

endmodule

// File: rtl/idle_ack_ctrl.sv
module idle_ack_ctrl
    import idle_ack_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter int N_DMA = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_req_i,
    input  logic [1:0]       idle_mode_i,
    input  logic [1:0]       clk_keep_i,
    input  logic             master_mode_i,
    input  logic             bus_pend_i,
    input  logic [N_IRQ-1:0] irq_pend_i,
    input  logic [N_DMA-1:0] dma_pend_i,
    input  logic             reg_access_i,
    input  logic             shift_busy_i,
    input  logic             cs_active_i,
    output logic             idle_ack_o,
    output logic             iclk_gate_en_o,
    output logic             fclk_gate_en_o
);
    logic pol_force, pol_active, chk_i, chk_f, stop_i_ok, stop_f_ok;
    logic busy_i, busy_f, blocked, grant;
    hs_state_t st_d, st_q;

    idle_pol_dec u_dec (
        .idle_mode_i  (idle_mode_i),
        .clk_keep_i   (clk_keep_i),
        .pol_force_o  (pol_force),
        .pol_active_o (pol_active),
        .chk_i_o      (chk_i),
        .chk_f_o      (chk_f),
        .stop_i_ok_o  (stop_i_ok),
        .stop_f_ok_o  (stop_f_ok)
    );

    idle_act_qual #(.N_IRQ(N_IRQ), .N_DMA(N_DMA)) u_qual (
        .master_mode_i (master_mode_i),
        .bus_pend_i    (bus_pend_i),
        .irq_pend_i    (irq_pend_i),
        .dma_pend_i    (dma_pend_i),
        .reg_access_i  (reg_access_i),
        .shift_busy_i  (shift_busy_i),
        .cs_active_i   (cs_active_i),
        .busy_i_o      (busy_i),
        .busy_f_o      (busy_f)
    );

    always_comb begin
        st_d    = st_q;
        blocked = (chk_i & busy_i) | (chk_f & busy_f);
        grant   = idle_req_i & (pol_force | (pol_active & ~blocked));
        if (!st_q.ack) begin
            if (grant) begin
                st_d.ack    = 1'b1;
                st_d.gate_i = pol_force | stop_i_ok;
                st_d.gate_f = pol_force | stop_f_ok;
            end
        end else if (!idle_req_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle_ack_o     = st_q.ack;
    assign iclk_gate_en_o = st_q.gate_i;
    assign fclk_gate_en_o = st_q.gate_f;

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_ack_o) |-> $past(idle_req_i)); // R10
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ack_o && idle_req_i) |=> idle_ack_o); // R10
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ack_o && !idle_req_i) |=> !idle_ack_o); // R10
    AST_NO_REFUSE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_ack_o) |-> !$past(idle_mode_i[0])); // R3 R4
    AST_HINT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (iclk_gate_en_o || fclk_gate_en_o) |-> idle_ack_o); // R11
    AST_QUIET_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(idle_ack_o) && $past(idle_mode_i) == 2'b10 && $past(clk_keep_i) == 2'b00)
        |-> $past(!busy_i && !busy_f)); // R5
    AST_HINT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ack_o && idle_req_i) |=> ($stable(iclk_gate_en_o) && $stable(fclk_gate_en_o))); // R11

endmodule

// File: tb/idle_ack_ctrl_tb.sv
module idle_ack_ctrl_tb;
    localparam int N_IRQ = 4;
    localparam int N_DMA = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_req_i = 1'b0;
    logic [1:0] idle_mode_i = 2'b01;
    logic [1:0] clk_keep_i = 2'b00;
    logic master_mode_i = 1'b1;
    logic bus_pend_i = 1'b0;
    logic [N_IRQ-1:0] irq_pend_i = '0;
    logic [N_DMA-1:0] dma_pend_i = '0;
    logic reg_access_i = 1'b0;
    logic shift_busy_i = 1'b0;
    logic cs_active_i = 1'b0;
    logic idle_ack_o, iclk_gate_en_o, fclk_gate_en_o;

    int n_tests = 0;
    int n_fail = 0;
    logic [2:0] exp_q[$];
    string tag_q[$];
    logic m_ack = 1'b0, m_gi = 1'b0, m_gf = 1'b0;

    always #10 clk = ~clk;

    idle_ack_ctrl #(.N_IRQ(N_IRQ), .N_DMA(N_DMA)) u_dut (
        .clk(clk), .rst_n(rst_n), .idle_req_i(idle_req_i), .idle_mode_i(idle_mode_i),
        .clk_keep_i(clk_keep_i), .master_mode_i(master_mode_i), .bus_pend_i(bus_pend_i),
        .irq_pend_i(irq_pend_i), .dma_pend_i(dma_pend_i), .reg_access_i(reg_access_i),
        .shift_busy_i(shift_busy_i), .cs_active_i(cs_active_i), .idle_ack_o(idle_ack_o),
        .iclk_gate_en_o(iclk_gate_en_o), .fclk_gate_en_o(fclk_gate_en_o)
    );

    task automatic check(input logic [2:0] got, input logic [2:0] exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {ack,gi,gf} got %b expected %b", tag, got, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and queue the predicted outputs
    task automatic step(input logic req, input logic [1:0] mode, input logic [1:0] keep,
                        input logic mst, input logic bus, input logic irq, input logic dma,
                        input logic rga, input logic sh, input logic cs, input string tag);
        logic bi, bf, ok;
        @(negedge clk);
        idle_req_i = req; idle_mode_i = mode; clk_keep_i = keep; master_mode_i = mst;
        bus_pend_i = bus; irq_pend_i = irq ? N_IRQ'(2) : '0; dma_pend_i = dma ? N_DMA'(1) : '0;
        reg_access_i = rga; shift_busy_i = sh; cs_active_i = cs;
        bi = bus | irq | dma | rga;
        bf = sh | (!mst & cs);
        if (!m_ack) begin
            ok = req && (mode == 2'b00 ||
                 (mode == 2'b10 && !(!keep[0] && bi) && !(!keep[1] && bf)));
            if (ok) begin
                m_ack = 1'b1;
                m_gi  = (mode == 2'b00) ? 1'b1 : !keep[0];
                m_gf  = (mode == 2'b00) ? 1'b1 : !keep[1];
            end
        end else if (!req) begin
            m_ack = 1'b0; m_gi = 1'b0; m_gf = 1'b0;
        end
        exp_q.push_back({m_ack, m_gi, m_gf});
        tag_q.push_back(tag);
    endtask

    // monitor: compare after each capturing edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                check({idle_ack_o, iclk_gate_en_o, fclk_gate_en_o}, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic release_req;
        step(0, 2'b01, 2'b00, 1, 0, 0, 0, 0, 0, 0, "R10 release");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #5 check({idle_ack_o, iclk_gate_en_o, fclk_gate_en_o}, 3'b000, "R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #5 check({idle_ack_o, iclk_gate_en_o, fclk_gate_en_o}, 3'b000, "R1 after reset");

        // R2 forced with every source busy
        step(1, 2'b00, 2'b11, 0, 1, 1, 1, 1, 1, 1, "R2 forced grant");
        step(1, 2'b01, 2'b11, 0, 1, 1, 1, 1, 1, 1, "R10 hold through policy change");
        step(0, 2'b00, 2'b11, 0, 1, 1, 1, 1, 1, 1, "R10 drop");
        step(0, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R10 no ack without req");

        // R3 / R4 refuse
        step(1, 2'b01, 2'b00, 1, 0, 0, 0, 0, 0, 0, "R3 refuse");
        step(1, 2'b01, 2'b00, 1, 0, 0, 0, 0, 0, 0, "R3 refuse hold");
        step(1, 2'b11, 2'b00, 1, 0, 0, 0, 0, 0, 0, "R4 unused code");
        step(1, 2'b11, 2'b11, 1, 0, 0, 0, 0, 0, 0, "R4 unused code keep11");
        release_req();

        // R5 both domains checked
        step(1, 2'b10, 2'b00, 1, 1, 0, 0, 0, 0, 0, "R5 bus pending blocks");
        step(1, 2'b10, 2'b00, 1, 0, 0, 1, 0, 0, 0, "R5 dma pending blocks");
        step(1, 2'b10, 2'b00, 1, 0, 0, 0, 0, 1, 0, "R5 shifter busy blocks");
        step(1, 2'b10, 2'b00, 1, 0, 0, 0, 0, 0, 0, "R5 quiet grant");
        step(1, 2'b10, 2'b11, 1, 1, 1, 1, 1, 1, 1, "R11 hints held");
        release_req();

        // R6 interface clock kept
        step(1, 2'b10, 2'b01, 1, 0, 0, 0, 0, 1, 0, "R6 functional busy blocks");
        step(1, 2'b10, 2'b01, 1, 1, 1, 1, 1, 0, 0, "R6 interface ignored");
        release_req();

        // R7 functional clock kept
        step(1, 2'b10, 2'b10, 1, 0, 1, 0, 0, 0, 0, "R7 irq blocks");
        step(1, 2'b10, 2'b10, 0, 0, 0, 0, 0, 1, 1, "R7 functional ignored");
        release_req();

        // R8 nothing checked
        step(1, 2'b10, 2'b11, 0, 1, 1, 1, 1, 1, 1, "R8 grant with all busy");
        release_req();

        // R9 chip select by role
        step(1, 2'b10, 2'b01, 0, 0, 0, 0, 0, 0, 1, "R9 slave cs blocks");
        step(1, 2'b10, 2'b01, 1, 0, 0, 0, 0, 0, 1, "R9 master cs ignored");
        release_req();

        // R12 register access in both roles
        step(1, 2'b10, 2'b10, 1, 0, 0, 0, 1, 0, 0, "R12 master access blocks");
        step(1, 2'b10, 2'b10, 0, 0, 0, 0, 1, 0, 0, "R12 slave access blocks");
        step(1, 2'b10, 2'b10, 0, 0, 0, 0, 0, 0, 0, "R12 grant after access");
        release_req();
        release_req();

        repeat (3) @(posedge clk);
        #6;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule